// File: doc/BRIEF.md
# Chainable Priority Encoder (16 requests, built from 8-request units)

This block turns a set of active-low request lines into the binary index of the most urgent asserted request. It is built from 8-request encoder units. Each unit has an active-low enable input, active-low code outputs, an active-low "this unit has a request" flag and an active-low pass-down enable. The units are chained so that a unit lower in the chain is enabled only when every unit above it is idle. The top level joins the units' outputs into one active-high code and one active-high valid flag. The logic is purely combinational.

With the default of two units, the top encodes 16 requests. Request 15 wins over all others. When the block is enabled and no request is present, the pass-down enable output goes low, so a further copy of this block can be hung below it.

Top module: `prienc_chain`

## Requirements
- R1: A request is asserted when its bit of `req_n` is 0; an all-ones `req_n` means no request.
- R2: With `en_n` = 0 and exactly one request asserted at index k (0..15), `code` equals k (bit 3 is the MSB) and `grp_valid` is 1.
- R3: With several requests asserted, `code` gives the highest asserted index.
- R4: Any asserted request in 15..8 overrides every request in 7..0, and `code[3]` is then 1.
- R5: With `en_n` = 0 and no request, `code` is 0000, `grp_valid` is 0 and `en_out_n` is 0.
- R6: With `en_n` = 1, `code` is 0000, `grp_valid` is 0 and `en_out_n` is 1, whatever the requests are.
- R7: With `en_n` = 0 and at least one request asserted, `en_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 16 | Active-low request lines; bit 15 has the highest priority |
| en_n | input | 1 | Active-low enable of the whole chain |
| code | output | 4 | Active-high index of the winning request, 0 when none |
| grp_valid | output | 1 | 1 when enabled and any request is asserted |
| en_out_n | output | 1 | Active-low enable for a further block below this one |

## Verification
The bench sweeps every single-request position. A design with a swapped or dropped code bit would show a wrong index at one of those positions. It pairs requests across the unit boundary and within each unit, so a chain that fails to mask the lower unit gives a merged, wrong code with bit 3 set. It also asserts requests while the block is disabled and checks the idle case while enabled, where a broken pass-down enable shows up on `en_out_n` or as a nonzero code.

// File: rtl/prienc_pkg.sv
package prienc_pkg;
    localparam int LANE_W = 8;
    localparam int CODE_W = $clog2(LANE_W);

    typedef struct packed {
        logic [CODE_W-1:0] code_n;
        logic              gs_n;
        logic              eo_n;
    } lane_out_t;
endpackage

// File: rtl/prienc_lane.sv
module prienc_lane
    import prienc_pkg::*;
(
    input  logic [LANE_W-1:0] req_n,
    input  logic              ei_n,
    output logic [CODE_W-1:0] code_n,
    output logic              gs_n,
    output logic              eo_n
);
    lane_out_t out_d;

    always_comb begin
        out_d.code_n = '1;
        out_d.gs_n   = 1'b1;
        out_d.eo_n   = 1'b1;
        if (!ei_n) begin
            out_d.eo_n = 1'b0;
            // ascending scan: the last asserted index found is the highest
            for (int i = 0; i < LANE_W; i++) begin
                if (!req_n[i]) begin
                    out_d.code_n = ~CODE_W'(i);
                    out_d.gs_n   = 1'b0;
                    out_d.eo_n   = 1'b1;
                end
            end
        end
    end

    assign code_n = out_d.code_n;
    assign gs_n   = out_d.gs_n;
    assign eo_n   = out_d.eo_n;

    always_comb begin
        if (ei_n)
            AST_LANE_DISABLED_IDLE: assert (code_n == '1 && gs_n && eo_n); // R6
        AST_LANE_FLAGS_EXCLUSIVE: assert (gs_n || eo_n); // R7
        if (!ei_n && !req_n[LANE_W-1])
            AST_LANE_TOP_WINS: assert (code_n == '0 && !gs_n); // R3
    end
endmodule

// File: rtl/prienc_chain.sv
module prienc_chain
    import prienc_pkg::*;
#(
    parameter  int UNITS  = 2,
    localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1,
    localparam int REQ_W  = UNITS * LANE_W,
    localparam int OUT_W  = UNIT_W + CODE_W
) (
    input  logic [REQ_W-1:0] req_n,
    input  logic             en_n,
    output logic [OUT_W-1:0] code,
    output logic             grp_valid,
    output logic             en_out_n
);
    logic [UNITS:0]        chain_n;
    logic [CODE_W-1:0]     unit_code_n [UNITS];
    logic [UNITS-1:0]      unit_gs_n;

    assign chain_n[UNITS] = en_n;

    // unit UNITS-1 sits at the top; each passes its enable down
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        prienc_lane u_lane (
            .req_n  (req_n[u*LANE_W +: LANE_W]),
            .ei_n   (chain_n[u+1]),
            .code_n (unit_code_n[u]),
            .gs_n   (unit_gs_n[u]),
            .eo_n   (chain_n[u])
        );
    end

    logic [UNIT_W-1:0] hi_d;
    logic [CODE_W-1:0] lo_n_d;

    always_comb begin
        hi_d   = '0;
        lo_n_d = '1;
        for (int u = 0; u < UNITS; u++) begin
            lo_n_d = lo_n_d & unit_code_n[u];
            if (!unit_gs_n[u])
                hi_d = hi_d | UNIT_W'(u);
        end
    end

    assign code      = {hi_d, ~lo_n_d};
    assign grp_valid = ~&unit_gs_n;
    assign en_out_n  = chain_n[0];

    always_comb begin
        AST_ONE_UNIT_ACTIVE: assert ($onehot0(~unit_gs_n)); // R4
        if (!grp_valid)
            AST_IDLE_CODE_ZERO: assert (code == '0); // R5
        if (en_n)
            AST_DISABLED_QUIET: assert (en_out_n && !grp_valid); // R6
        if (grp_valid)
            AST_BUSY_BLOCKS_DOWN: assert (en_out_n); // R7
    end
endmodule

// File: tb/sim_prienc_chain.sv
module sim_prienc_chain;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    typedef struct {
        logic [3:0] code;
        logic       valid;
        logic       eo_n;
        string      tag;
    } exp_t;

    logic         clk = 1'b0;
    logic [N-1:0] req_n = '1;
    logic         en_n = 1'b1;
    logic [3:0]   code;
    logic         grp_valid;
    logic         en_out_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    prienc_chain u0 (
        .req_n(req_n), .en_n(en_n), .code(code),
        .grp_valid(grp_valid), .en_out_n(en_out_n)
    );

    task automatic apply(input logic [N-1:0] r, input logic e, input string tag);
        exp_t x;
        x.code = 4'd0; x.valid = 1'b0; x.eo_n = 1'b1; x.tag = tag;
        if (!e) begin
            x.eo_n = 1'b0;
            for (int i = 0; i < N; i++)
                if (!r[i]) begin x.code = 4'(i); x.valid = 1'b1; x.eo_n = 1'b1; end
        end
        @(posedge clk);
        req_n <= r;
        en_n  <= e;
        sb.push_back(x);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            tests++;
            if (code !== x.code || grp_valid !== x.valid || en_out_n !== x.eo_n) begin
                fails++;
                $display("FAIL %s: code=%0d valid=%b eo_n=%b expected code=%0d valid=%b eo_n=%b",
                         x.tag, code, grp_valid, en_out_n, x.code, x.valid, x.eo_n);
            end
        end
    end

    initial begin
        apply('1, 1'b1, "R6 initial idle");
        apply('1, 1'b0, "R5 R1 enabled, all ones means none");
        for (int k = 0; k < N; k++)
            apply(~(16'd1 << k), 1'b0, $sformatf("R2 single request %0d", k));
        apply(16'b1111_1111_0101_0110, 1'b0, "R3 lower unit multi");
        apply(16'b1010_1101_1111_1111, 1'b0, "R3 upper unit multi");
        apply(16'h0000, 1'b0, "R3 all asserted");
        apply(16'b1111_1110_0111_1111, 1'b0, "R4 req 8 over req 7");
        apply(16'b1011_1111_0000_0000, 1'b0, "R4 req 14 over lower unit");
        apply(16'h0000, 1'b1, "R6 disabled with all requests");
        apply(16'b1111_1111_1111_1110, 1'b1, "R6 disabled with req 0");
        apply(16'b0111_1111_1111_1111, 1'b1, "R6 disabled with req 15");
        apply(16'b1111_1111_1111_1110, 1'b0, "R7 busy low request");
        apply(16'b1111_1111_1111_1111, 1'b0, "R5 idle again");
        for (int k = 0; k < 40; k++)
            apply(16'((k * 16'h9e37) ^ 16'hffff) | 16'(k[0] ? 16'h00ff : 16'h0), 1'b0, "R3 mixed pattern");
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule